// File: doc/BRIEF.md
# Polled Byte-Exchange SPI Master

This block is a memory-mapped SPI master that swaps one 8-bit word with a serial target on every launch. Software sets the clock divider and clock mode in a configuration word. It drives the chip-select line by writing a bit in a system word. It starts an exchange by writing the outgoing byte, then polls a status word until the exchange is over and reads the incoming byte back.

The serial clock comes from the module clock in two stages. The first stage divides by a fixed 16 or 128. The second stage is a programmable even divide of (N+1)*2, where N is a 5-bit value. The clock idle level and the sampling edge can be set. Data moves most significant bit first. Accesses are 32 bits wide at word offsets, and only the low byte of each register is used.

Top module: `spi_xfer_master`

## Requirements
- R1: After reset, csN is 1, sclk is 0 and mosi is 0. The status word (offset 0x04) reads 0, the system word (offset 0x08) reads 0x40 and the configuration word (offset 0x00) reads 0.
- R2: The configuration word (0x00), the system word (0x08) and the spare word (0x14) store bits 7:0 of a write and read back with bits 31:8 at zero. An offset with no register, such as 0x18, reads 0.
- R3: While an exchange runs, each half period of sclk lasts P*(N+1) module clocks. P is 16 when configuration bit 5 is 0 and 128 when it is 1, and N is configuration bits 4:0.
- R4: Configuration bit 6 sets the sclk idle level and bit 7 sets the phase. With phase 0, data is sampled on the first edge of each bit. With phase 1, it is sampled on the second edge and mosi changes on the first. The byte goes out on mosi MSB first, and the byte sampled from miso, MSB first, is later read from offset 0x10 in bits 7:0.
- R5: Status bit 0 (busy) is 1 from the clock edge that takes a write to offset 0x0C. It falls on the edge that ends the 16th half period.
- R6: Status bit 2 (received-byte flag) is set when an exchange ends. A read of offset 0x10 clears it, and so does a write to offset 0x04 with bit 2 at 0.
- R7: A write to offset 0x0C while busy is 1 is ignored. The byte in flight is unchanged, and no second exchange follows.
- R8: If an exchange ends on the same clock edge as a read of 0x10 or a clearing write to 0x04, the received-byte flag stays set.
- R9: The csN pin follows system-word bit 6. Writing 0x21 drives it low, and writing 0x61 drives it high.
- R10: When no exchange is running, sclk sits at the level set by configuration bit 6, and mosi keeps the last bit it sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Register access strobe, one cycle |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 5 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of busSel |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 1 | Chip select, active low |

## Verification
The received-byte flag can be set by the end of an exchange and cleared by software in the same cycle, either through a read of the receive word or through a clearing write to the status word. The bench counts module clocks from the launching write and places the read, or the clearing write, on exactly the edge of the 16th half period. It then checks that the flag still reads 1 and that a later read of the receive word returns the new byte, not the old one.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  typedef struct packed {
    logic load;   // launch a new exchange
    logic lead;   // first edge of a bit
    logic trail;  // second edge of a bit
    logic done;   // last trailing edge of the word
  } xferStb_t;

  localparam logic [2:0] IDX_CFG   = 3'd0;
  localparam logic [2:0] IDX_STAT  = 3'd1;
  localparam logic [2:0] IDX_SYS   = 3'd2;
  localparam logic [2:0] IDX_TX    = 3'd3;
  localparam logic [2:0] IDX_RX    = 3'd4;
  localparam logic [2:0] IDX_SPARE = 3'd5;
endpackage

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 5,
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txReq,
  input  logic             preSel,
  input  logic [DIV_W-1:0] divN,
  output logic             busy,
  output logic             lvl,
  output xferStb_t         stb
);
  localparam int CNT_W  = $clog2(PRE_HI * (2 ** DIV_W)) + 1;
  localparam int EDGE_N = 2 * WORD_W;
  localparam int EDGE_W = $clog2(EDGE_N);

  logic [CNT_W-1:0]  halfLen;
  logic [CNT_W-1:0]  cnt;
  logic [EDGE_W-1:0] edgeIdx;
  logic              tick;

  always_comb begin
    halfLen = (preSel ? CNT_W'(PRE_HI) : CNT_W'(PRE_LO)) * (CNT_W'(divN) + CNT_W'(1));
    tick    = busy && (cnt >= halfLen - CNT_W'(1));
    stb.load  = txReq && !busy;
    stb.lead  = tick && !edgeIdx[0];
    stb.trail = tick && edgeIdx[0];
    stb.done  = tick && (edgeIdx == EDGE_W'(EDGE_N - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      cnt     <= '0;
      edgeIdx <= '0;
      lvl     <= 1'b0;
    end else if (stb.load) begin
      busy    <= 1'b1;
      cnt     <= '0;
      edgeIdx <= '0;
    end else if (busy) begin
      if (tick) begin
        cnt     <= '0;
        edgeIdx <= edgeIdx + EDGE_W'(1);
        lvl     <= ~lvl;
        if (stb.done) busy <= 1'b0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  p_load_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> busy);
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.done |=> !busy);
  p_no_edge_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(stb.lead || stb.trail));
endmodule

// File: rtl/spi_xfer_dp.sv
module spi_xfer_dp
  import spi_xfer_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 5,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              miso,
  input  logic              busy,
  input  xferStb_t          stb,
  output logic              txReq,
  output logic              preSel,
  output logic [DIV_W-1:0]  divN,
  output logic              cpol,
  output logic              mosi,
  output logic              csN
);
  logic [7:0]        cfgReg, sysReg, spareReg;
  logic [WORD_W-1:0] shReg, rxSh, rxBuf, rxNext;
  logic              rxFull, mosiReg, cpha, wr, rd;
  logic [2:0]        idx;
  logic              unusedBits;

  assign idx        = busAddr[4:2];
  assign wr         = busSel && busWrite;
  assign rd         = busSel && !busWrite;
  assign txReq      = wr && (idx == IDX_TX);
  assign cpha       = cfgReg[7];
  assign cpol       = cfgReg[6];
  assign preSel     = cfgReg[5];
  assign divN       = cfgReg[DIV_W-1:0];
  assign csN        = sysReg[6];
  assign mosi       = mosiReg;
  assign rxNext     = {rxSh[WORD_W-2:0], miso};
  assign unusedBits = ^{busWdata[31:8], busAddr[1:0], busAddr[ADDR_W-1:2] == '0};

  always_comb begin
    case (idx)
      IDX_CFG:   busRdata = 32'(cfgReg);
      IDX_STAT:  busRdata = 32'({rxFull, 1'b0, busy});
      IDX_SYS:   busRdata = 32'(sysReg);
      IDX_RX:    busRdata = 32'(rxBuf);
      IDX_SPARE: busRdata = 32'(spareReg);
      default:   busRdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg   <= '0;
      sysReg   <= 8'h40;
      spareReg <= '0;
    end else if (wr) begin
      if (idx == IDX_CFG)   cfgReg   <= busWdata[7:0];
      if (idx == IDX_SYS)   sysReg   <= busWdata[7:0];
      if (idx == IDX_SPARE) spareReg <= busWdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull <= 1'b0;
      rxBuf  <= '0;
    end else if (stb.done) begin
      rxFull <= 1'b1;
      rxBuf  <= cpha ? rxNext : rxSh;
    end else if ((rd && idx == IDX_RX) || (wr && idx == IDX_STAT && !busWdata[2])) begin
      rxFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      rxSh    <= '0;
      mosiReg <= 1'b0;
    end else if (stb.load) begin
      if (!cpha) begin
        mosiReg <= busWdata[WORD_W-1];
        shReg   <= busWdata[WORD_W-1:0] << 1;
      end else begin
        shReg   <= busWdata[WORD_W-1:0];
      end
    end else if (stb.lead) begin
      if (!cpha) begin
        rxSh    <= rxNext;
      end else begin
        mosiReg <= shReg[WORD_W-1];
        shReg   <= shReg << 1;
      end
    end else if (stb.trail) begin
      if (cpha) begin
        rxSh    <= rxNext;
      end else if (!stb.done) begin
        mosiReg <= shReg[WORD_W-1];
        shReg   <= shReg << 1;
      end
    end
  end

  p_done_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.done |=> rxFull);
  p_busy_write_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && txReq && !stb.lead && !stb.trail) |=> $stable(shReg));
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spi_xfer_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 5,
  parameter int ADDR_W = 5,
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              csN
);
  xferStb_t         stb;
  logic             busy, lvl, txReq, preSel, cpol;
  logic [DIV_W-1:0] divN;

  spi_xfer_ctrl #(.WORD_W(WORD_W), .DIV_W(DIV_W), .PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) i_ctrl (
    .clk(clk), .rstN(rstN), .txReq(txReq), .preSel(preSel), .divN(divN),
    .busy(busy), .lvl(lvl), .stb(stb));

  spi_xfer_dp #(.WORD_W(WORD_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .miso(miso), .busy(busy), .stb(stb),
    .txReq(txReq), .preSel(preSel), .divN(divN), .cpol(cpol), .mosi(mosi), .csN(csN));

  assign sclk = lvl ^ cpol;

  p_idle_sclk_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sclk == cpol));
  p_idle_mosi_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> $stable(mosi));
endmodule

// File: tb/test_spi_xfer_master.sv
module test_spi_xfer_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        sclk, mosi, csN;
  logic        miso = 1'b0;

  int  passCnt = 0, totalCnt = 0;
  bit  ended = 0;
  logic [7:0] expMosi[$];
  logic       cpolTb = 0, cphaTb = 0;
  logic [7:0] slvSh, slvRx;
  int         slvCnt;
  int         halfTb;
  time        lastEdge;
  bit         edgeSeen;
  logic [31:0] rdv;

  spi_xfer_master i_spi_xfer_master (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    totalCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", passCnt, totalCnt);
      $finish;
    end
  endtask

  // all bus tasks are entered at a negedge and return at the next negedge
  task automatic busW(input logic [4:0] a, input logic [31:0] d);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic busR(input logic [4:0] a, output logic [31:0] d);
    busSel = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 0;
  endtask

  // bench-side SPI target and scoreboard monitor
  always @(sclk) begin
    if (rstN && !csN) begin
      if (edgeSeen) chk(($time - lastEdge) == time'(halfTb * 10), "R3 half period",
                        32'($time - lastEdge), 32'(halfTb * 10));
      edgeSeen = 1;
      lastEdge = $time;
      if ((sclk != cpolTb) != cphaTb) begin
        slvRx = {slvRx[6:0], mosi};
        slvCnt++;
        if (slvCnt == 8) begin
          if (expMosi.size() == 0) chk(0, "R7 unexpected exchange", 32'(slvRx), 0);
          else begin
            logic [7:0] e;
            e = expMosi.pop_front();
            chk(slvRx == e, "R4 mosi byte", 32'(slvRx), 32'(e));
          end
          slvCnt = 0;
        end
      end else begin
        miso = slvSh[7];
        slvSh = slvSh << 1;
      end
    end
  end

  // mode: 0 plain, 1 rx read on final edge, 2 status clear on final edge, 3 tx write while busy
  task automatic xfer(input logic [7:0] txB, input logic [7:0] rxB, input logic pol,
                      input logic pha, input logic pre, input logic [4:0] n, input int mode);
    int spent;
    busW(5'h08, 32'h61);
    cpolTb = pol; cphaTb = pha;
    busW(5'h00, {24'h0, pha, pol, pre, n});
    halfTb = (pre ? 128 : 16) * (n + 1);
    chk(sclk == pol, "R10 idle sclk level", 32'(sclk), 32'(pol));
    busW(5'h08, 32'h21);
    slvSh = rxB; slvCnt = 0; edgeSeen = 0;
    if (!pha) begin miso = slvSh[7]; slvSh = slvSh << 1; end
    expMosi.push_back(txB);
    busW(5'h0C, 32'(txB));
    busR(5'h04, rdv);
    chk(rdv[0] == 1, "R5 busy after launch", rdv, 1);
    spent = 1;
    if (mode == 3) begin busW(5'h0C, 32'(~txB)); spent = 2; end
    repeat (16 * halfTb - 1 - spent) @(negedge clk);
    if (mode == 1) busR(5'h10, rdv);
    else if (mode == 2) busW(5'h04, 32'h0);
    else begin
      busR(5'h04, rdv);
      chk(rdv[0] == 1, "R5 busy before final edge", rdv, 1);
    end
    busR(5'h04, rdv);
    chk(rdv[2:0] == 3'b100, (mode == 1 || mode == 2) ? "R8 flag survives collision" : "R5 R6 done status",
        32'(rdv[2:0]), 32'h4);
    busR(5'h10, rdv);
    chk(rdv == 32'(rxB), "R4 received byte", rdv, 32'(rxB));
    busR(5'h04, rdv);
    chk(rdv[2] == 0, "R6 read clears flag", rdv, 0);
    chk(mosi == txB[0] && sclk == pol, "R10 idle mosi holds last bit",
        32'({sclk, mosi}), 32'({pol, txB[0]}));
    busW(5'h08, 32'h61);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(csN == 1 && sclk == 0 && mosi == 0, "R1 reset pins", 32'({csN, sclk, mosi}), 32'h4);
    rstN = 1;
    @(negedge clk);
    busR(5'h04, rdv); chk(rdv == 0, "R1 status reset", rdv, 0);
    busR(5'h08, rdv); chk(rdv == 32'h40, "R1 system reset", rdv, 32'h40);
    busR(5'h00, rdv); chk(rdv == 0, "R1 config reset", rdv, 0);

    busW(5'h00, 32'hFFFF_FF25); busR(5'h00, rdv); chk(rdv == 32'h25, "R2 config readback", rdv, 32'h25);
    busW(5'h14, 32'h1234_5678); busR(5'h14, rdv); chk(rdv == 32'h78, "R2 spare readback", rdv, 32'h78);
    busR(5'h18, rdv); chk(rdv == 0, "R2 empty offset", rdv, 0);
    busW(5'h00, 32'h0);

    busW(5'h08, 32'h21); chk(csN == 0, "R9 cs asserted", 32'(csN), 0);
    busR(5'h08, rdv); chk(rdv == 32'h21, "R2 system readback", rdv, 32'h21);
    busW(5'h08, 32'h61); chk(csN == 1, "R9 cs released", 32'(csN), 1);

    xfer(8'hA5, 8'h3C, 0, 0, 0, 5'd0, 0);
    xfer(8'h96, 8'hE1, 0, 1, 0, 5'd1, 0);
    xfer(8'h0F, 8'h81, 1, 0, 0, 5'd0, 0);
    xfer(8'hC3, 8'h5A, 1, 1, 1, 5'd0, 0);
    xfer(8'h71, 8'h8E, 0, 0, 0, 5'd3, 3);
    xfer(8'h2B, 8'hD4, 0, 1, 0, 5'd0, 1);
    xfer(8'hE6, 8'h19, 1, 0, 0, 5'd1, 2);

    repeat (300) @(negedge clk);
    chk(expMosi.size() == 0, "R7 scoreboard drained", 32'(expMosi.size()), 0);
    busR(5'h04, rdv); chk(rdv == 0, "R7 no extra exchange", rdv, 0);
    finishRun();
  end
endmodule